// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a self-timed non-volatile memory. While an internal program or erase is running, the array cannot deliver real data. Each host read then returns a status byte, and the host uses it to tell when the operation has finished. When no operation is running, array data passes straight through. The block also drives a shared, open-drain ready/busy line for as long as the internal operation lasts.

The status byte carries two completion indicators. The polling bit (bit 7) depends on the kind of operation. During a program, a read of the location just written returns the inverse of the bit 7 that was written. During an erase, every read returns 0 in bit 7. The toggle bit (bit 6) changes once for each read access that starts while an operation is running. It does not change with the clock, so a host that compares two consecutive reads sees a difference only while work is still in progress.

The decision between status and true data is taken at the start of each read. That means the read starting in the cycle that busy goes high already returns status, and the first read starting after busy goes low returns true data. A change of busy during a read does not alter that read. The read strobe and the status inputs are plain level signals. There is no handshake, because the host read cycle has a fixed length.

Top module: `op_status_reporter`

## Requirements
- R1: After reset, the ready/busy pull enable is low, the ready/busy level output is 0, and the toggle state is cleared, so the first status read after reset returns 1 in bit 6.
- R2: A read whose start (rising edge of `rd_strobe`) finds `op_busy` low returns `array_data` unchanged on all 8 bits, for the whole read.
- R3: In a read that starts while busy and with `op_is_erase` low (a program), bit 7 is the inverse of `last_data[7]` when `addr_match` is high.
- R4: In a program status read with `addr_match` low, bit 7 carries `array_data[7]`.
- R5: In a read that starts while busy and with `op_is_erase` high, bit 7 is 0 whatever the other inputs are.
- R6: In each read that starts while busy, bit 6 is the inverse of the value it had in the previous such read. Within one read it stays constant.
- R7: In every status read, bits 5 to 0 carry `array_data[5:0]`.
- R8: `rb_pull_en` is high in exactly the cycles in which `op_busy` is high, with no added latency. `rb_level` is always 0.
- R9: Whether a read returns status or true data, and which operation type applies, is fixed by the inputs in the cycle where the read starts. A change of `op_busy` later in the same read changes neither.
- R10: Reads that start while not busy leave the toggle state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_busy | input | 1 | Internal program or erase in progress |
| op_is_erase | input | 1 | 1 = the running operation is an erase, 0 = a program |
| last_data | input | 8 | Data most recently loaded for programming |
| addr_match | input | 1 | Current read address equals the location being programmed |
| rd_strobe | input | 1 | High for the duration of a host read access |
| array_data | input | 8 | True data read from the array |
| rd_data | output | 8 | Data returned to the host |
| rb_pull_en | output | 1 | Enable of the open-drain ready/busy driver (1 = pull low) |
| rb_level | output | 1 | Value driven on ready/busy when enabled (always 0) |

## Verification
Two things can land in the same cycle: a read that starts and an edge of `op_busy`. The bench starts reads exactly in the cycle where busy rises, and it drops busy while a status read is held open. It expects the mode that was present when the read started, while `rb_pull_en` follows busy at once. The toggle advance and the polling rule also act on the same read start. Random reads mix operation type, address match and data. A bench model predicts each byte: it inverts its own toggle copy only for reads that start while busy.

// File: rtl/status_pkg.sv
package status_pkg;
  // Mode captured at the start of a host read
  typedef struct packed {
    logic busy;
    logic erase;
  } read_mode_t;

  localparam read_mode_t MODE_IDLE = '{busy: 1'b0, erase: 1'b0};
endpackage

// File: rtl/sr_read_tracker.sv
module sr_read_tracker
  import status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_strobe,
  input  logic       op_busy,
  input  logic       op_is_erase,
  output logic       rd_start,
  output read_mode_t cur_mode
);
  logic       strobe_q;
  read_mode_t held_mode;
  read_mode_t live_mode;

  assign rd_start  = rd_strobe & ~strobe_q;
  assign live_mode = '{busy: op_busy, erase: op_is_erase};

  // In the first cycle of a read the live inputs decide; afterwards the snapshot holds
  assign cur_mode = rd_start ? live_mode : held_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      held_mode <= MODE_IDLE;
    end else begin
      strobe_q <= rd_strobe;
      if (rd_start) held_mode <= live_mode;
    end
  end
endmodule

// File: rtl/sr_toggle_unit.sv
module sr_toggle_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic start_busy,
  output logic tog_shown
);
  logic tog_q;
  logic advance;

  assign advance = rd_start & start_busy;
  // New value is visible in the same cycle the read begins
  assign tog_shown = advance ? ~tog_q : tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (advance) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/sr_bit_merge.sv
module sr_bit_merge #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              show_status,
  input  logic              erase_op,
  input  logic              addr_match,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              tog_bit,
  output logic [DATA_W-1:0] rd_data
);
  logic poll_val;

  always_comb begin
    if (erase_op)        poll_val = 1'b0;
    else if (addr_match) poll_val = ~last_data[POLL_BIT];
    else                 poll_val = array_data[POLL_BIT];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign rd_data[i] = show_status ? poll_val : array_data[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign rd_data[i] = show_status ? tog_bit : array_data[i];
    end else begin : g_pass
      assign rd_data[i] = array_data[i];
    end
  end
endmodule

// File: rtl/op_status_reporter.sv
module op_status_reporter
  import status_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_busy,
  input  logic              op_is_erase,
  input  logic [DATA_W-1:0] last_data,
  input  logic              addr_match,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rb_pull_en,
  output logic              rb_level
);
  logic       rd_start;
  read_mode_t cur_mode;
  logic       tog_bit;
  logic       show_status;

  sr_read_tracker u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .op_busy    (op_busy),
    .op_is_erase(op_is_erase),
    .rd_start   (rd_start),
    .cur_mode   (cur_mode)
  );

  sr_toggle_unit u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_start  (rd_start),
    .start_busy(op_busy),
    .tog_shown (tog_bit)
  );

  assign show_status = rd_strobe & cur_mode.busy;

  sr_bit_merge #(
    .DATA_W    (DATA_W),
    .POLL_BIT  (POLL_BIT),
    .TOGGLE_BIT(TOGGLE_BIT)
  ) u_merge (
    .show_status(show_status),
    .erase_op   (cur_mode.erase),
    .addr_match (addr_match),
    .last_data  (last_data),
    .array_data (array_data),
    .tog_bit    (tog_bit),
    .rd_data    (rd_data)
  );

  // Open-drain ready/busy: enable follows busy directly, level is tied low
  assign rb_pull_en = op_busy;
  assign rb_level   = 1'b0;
endmodule

// File: rtl/op_status_reporter_chk.sv
module op_status_reporter_chk #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_busy,
  input logic              op_is_erase,
  input logic [DATA_W-1:0] last_data,
  input logic              addr_match,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rb_pull_en
);
  logic prev_strobe;
  logic last_tog;
  logic start_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_strobe <= 1'b0;
    else        prev_strobe <= rd_strobe;
  end
  assign start_c = rd_strobe & ~prev_strobe;

  AST_RB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> rb_pull_en); // R8

  AST_RB_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(op_busy) |-> !rb_pull_en); // R8

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !op_busy) |-> (rd_data == array_data)); // R2

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && op_busy && !op_is_erase && addr_match)
      |-> (rd_data[POLL_BIT] == ~last_data[POLL_BIT])); // R3

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && op_busy && op_is_erase) |-> !rd_data[POLL_BIT]); // R5

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && op_busy) |-> (rd_data[5:0] == array_data[5:0])); // R7

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tog <= 1'b0;
    end else if (start_c && op_busy) begin
      AST_TOGGLE_FLIP: assert (rd_data[TOGGLE_BIT] != last_tog); // R6
      last_tog <= rd_data[TOGGLE_BIT];
    end
  end
endmodule

bind op_status_reporter op_status_reporter_chk #(
  .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_is_erase(op_is_erase),
  .last_data(last_data), .addr_match(addr_match), .rd_strobe(rd_strobe),
  .array_data(array_data), .rd_data(rd_data), .rb_pull_en(rb_pull_en)
);

// File: tb/tb_op_status_reporter.sv
module tb_op_status_reporter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_busy = 1'b0;
  logic       op_is_erase = 1'b0;
  logic [7:0] last_data = 8'h00;
  logic       addr_match = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] rd_data;
  logic       rb_pull_en;
  logic       rb_level;

  int  checks = 0;
  int  errors = 0;
  logic exp_tog = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  op_status_reporter dut (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_is_erase(op_is_erase),
    .last_data(last_data), .addr_match(addr_match), .rd_strobe(rd_strobe),
    .array_data(array_data), .rd_data(rd_data), .rb_pull_en(rb_pull_en),
    .rb_level(rb_level)
  );

  function automatic logic [7:0] model(input logic busy, input logic erase,
      input logic match, input logic [7:0] last, input logic [7:0] arr,
      input logic tog);
    logic [7:0] r;
    r = arr;
    if (busy) begin
      r[6] = tog;
      r[7] = erase ? 1'b0 : (match ? ~last[7] : arr[7]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One read: start in one cycle, hold for one more, busy may change mid-read
  task automatic do_read(input logic busy, input logic erase, input logic match,
      input logic [7:0] last, input logic [7:0] arr, input logic busy_mid,
      input string req);
    logic [7:0] exp;
    @(negedge clk);
    op_busy = busy; op_is_erase = erase; addr_match = match;
    last_data = last; array_data = arr; rd_strobe = 1'b1;
    #2;
    if (busy) exp_tog = ~exp_tog;
    exp = model(busy, erase, match, last, arr, exp_tog);
    chk(req, rd_data, exp);
    chk("R8", {7'b0, rb_pull_en}, {7'b0, busy});
    @(negedge clk);
    op_busy = busy_mid;
    #2;
    chk({req, "/R9 held"}, rd_data, exp);
    chk("R8 mid", {6'b0, rb_level, rb_pull_en}, {6'b0, 1'b0, busy_mid});
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset", {6'b0, rb_level, rb_pull_en}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {6'b0, rb_level, rb_pull_en}, 8'h00);

    do_read(0, 0, 0, 8'h00, 8'hA5, 0, "R2 idle pass");
    do_read(1, 0, 1, 8'h80, 8'h3C, 1, "R1 R3 first status read");
    do_read(1, 0, 1, 8'h00, 8'h3C, 1, "R3 poll inverse");
    do_read(1, 0, 0, 8'h00, 8'hC7, 1, "R4 no match");
    do_read(1, 1, 1, 8'h00, 8'hFF, 1, "R5 erase poll");
    do_read(0, 0, 0, 8'h00, 8'h5A, 0, "R10 idle read");
    do_read(1, 1, 0, 8'h7F, 8'h2B, 1, "R6 R10 toggle resume");
    do_read(1, 0, 1, 8'h80, 8'h15, 0, "R9 busy falls mid read");
    do_read(0, 0, 1, 8'h80, 8'hE1, 1, "R9 busy rises mid read");
    do_read(0, 1, 1, 8'h00, 8'h99, 0, "R2 R9 first read after done");

    // Read starting in the cycle busy rises
    @(negedge clk); op_busy = 1'b0;
    do_read(1, 0, 0, 8'h00, 8'h6E, 1, "R9 start with busy rise");

    for (int k = 0; k < 300; k++) begin
      logic b, e, m, bm;
      b = 1'($urandom); e = 1'($urandom); m = 1'($urandom); bm = 1'($urandom);
      do_read(b, e, m, 8'($urandom), 8'($urandom), bm, "R6 R7 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule